// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block turns single-word reads from a memory-mapped window into complete serial flash read transactions. It sits next to a command engine that shares the same flash pins. A switch register decides which of the two owns the pins. While the memory-mapped path is off, any read from the window is refused with an error and the pins stay idle.

Each chip select has its own setup register. That register holds the read opcode, the address length in bytes, the number of dummy bytes and the data-line mode. A read selects a chip select and a byte address. The block drives that chip select low and sends the opcode and address on one line, most significant bit first. It then idles the data lines for the dummy bytes and shifts in one data word on one, two or four lines. The word is returned with the first received byte in the lowest byte lane.

The serial clock idles low. Output data changes after falling edges and input data is captured on rising edges. The clock half-period is a parameter counted in system clocks.

Top module: `flash_mm_xlate`

## Requirements
- R1: Writing offset 0x64 sets the switch from bit 0 of the write data; `mm_path_en` shows the stored bit from the cycle after the write.
- R2: A read issued while the switch is clear completes with a one-cycle `rd_ready` pulse and `rd_err` high, with no chip select asserted and no serial clock edge.
- R3: The setup register for chip select n sits at offset 0x54 + 4*n. Its fields are opcode in [7:0], address bytes minus one in [9:8], dummy byte count in [11:10] and line mode in [13:12]. A write to any other offset leaves every setup register unchanged.
- R4: A transaction first sends the opcode and then the low (address bytes) bytes of `rd_addr`, highest byte first, all MSB first on `flash_io_out[0]` with `flash_io_oe` = 0001. Every bit is stable at a rising serial clock edge, and the clock is low whenever no chip select is asserted.
- R5: After the address, the block runs 8 serial clock cycles per dummy byte with `flash_io_oe` = 0000.
- R6: Line modes 0 and 2 capture one data bit per rising edge from `flash_io_in[1]`, for 32 edges.
- R7: Line mode 1 captures two bits per rising edge from `flash_io_in[1:0]`, with bit 1 as the earlier bit, for 16 edges.
- R8: Line mode 3 captures four bits per rising edge from `flash_io_in[3:0]`, with bit 3 as the earliest bit, for 8 edges.
- R9: Data arrives MSB first within each byte. The first received byte is returned in `rd_data[7:0]` and the fourth in `rd_data[31:24]`.
- R10: `rd_ready` stays low until the final rising edge of the transaction has been taken. It then pulses for exactly one cycle with `rd_err` low.
- R11: Only the chip select named by `rd_cs` goes low. Between two transactions every chip select stays high for at least 2*SCK_HALF system clocks.
- R12: After reset all chip selects are high, the serial clock is low, `flash_io_oe` is 0000, `rd_ready` is low and the switch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| mm_path_en | output | 1 | Switch state: high means the memory-mapped path owns the pins |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_cs | input | CS_W | Chip select index of the read |
| rd_addr | input | 32 | Flash byte address of the read |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read word, first flash byte in the low lane |
| rd_err | output | 1 | Read refused, valid with `rd_ready` |
| flash_sck | output | 1 | Serial clock |
| flash_cs_n | output | NCS | Active-low chip selects |
| flash_io_out | output | 4 | Data line output values |
| flash_io_oe | output | 4 | Data line output enables |
| flash_io_in | input | 4 | Data line input values |

## Verification
The assertions rely on the requester keeping `rd_valid` high, with `rd_cs` and `rd_addr` stable, until `rd_ready`, and then dropping it for at least one cycle. They also assume that registers are not rewritten while a transaction is running. The bench drives each read from a task that raises the request on a falling clock edge, holds it until it sees the completion pulse, and then drops it. It writes setup and switch registers only between reads. The flash side is a bench model that counts rising serial clock edges from the chip select fall. It records the header bits, drives each data unit as soon as the previous rising edge has passed, and flags any output enable that differs from what the current phase requires.

// File: rtl/flash_mm_pkg.sv
package flash_mm_pkg;

  localparam int SETUP_BASE = 'h54;
  localparam int SWITCH_OFS = 'h64;
  localparam int HDR_MAX    = 40;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_DUMMY,
    S_DATA,
    S_GAP
  } seq_state_e;

  // Field order matches the setup register bit layout, [13:0].
  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] dummy;
    logic [1:0] addr_m1;
    logic [7:0] opcode;
  } setup_t;

  // Number of data lines used by a line-mode code.
  function automatic logic [2:0] lane_count(input logic [1:0] mode);
    case (mode)
      2'd3:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // log2 of the lane count, used as a shift amount.
  function automatic logic [1:0] lane_shift(input logic [1:0] mode);
    case (mode)
      2'd3:    return 2'd2;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/flash_mm_cfg.sv
module flash_mm_cfg
  import flash_mm_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic                 sw_en,
  output setup_t [NCS-1:0]     setup_q
);

  localparam logic [AW-1:0] SW_ADDR = AW'(SWITCH_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en <= 1'b0;
    end else if (cfg_we && cfg_addr == SW_ADDR) begin
      sw_en <= cfg_wdata[0];
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_setup
    localparam logic [AW-1:0] MY_ADDR = AW'(SETUP_BASE + 4 * i);
    always_ff @(posedge clk) begin
      if (rst) begin
        setup_q[i] <= '0;
      end else if (cfg_we && cfg_addr == MY_ADDR) begin
        setup_q[i] <= setup_t'(cfg_wdata[13:0]);
      end
    end
  end

  // R1: the switch takes bit 0 of a write to its offset
  p_switch_load_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == SW_ADDR) |=> (sw_en == $past(cfg_wdata[0])));

  // R1: without a write to its offset the switch holds
  p_switch_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == SW_ADDR) |=> $stable(sw_en));

endmodule

// File: rtl/flash_mm_sck.sv
module flash_mm_sck #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);

  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

  logic [CW-1:0] cnt;
  logic          phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign sck  = phase;
  assign rise = run && (cnt == LAST) && !phase;
  assign fall = run && (cnt == LAST) && phase;

  // R4: the clock drops back low once the sequencer stops it
  p_sck_stop_r4: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);

endmodule

// File: rtl/flash_mm_seq.sv
module flash_mm_seq
  import flash_mm_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int CS_W     = 2,
  parameter int DATA_W   = 32,
  parameter int SCK_HALF = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mm_en,
  input  setup_t [NCS-1:0]     setup_q,
  input  logic                 rd_valid,
  input  logic [CS_W-1:0]      rd_cs,
  input  logic [31:0]          rd_addr,
  input  logic [3:0]           io_in,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  output logic                 run,
  output logic                 rd_ready,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_err,
  output logic [NCS-1:0]       cs_n,
  output logic [3:0]           io_out,
  output logic [3:0]           io_oe
);

  localparam int NB    = DATA_W / 8;
  localparam int GAP_N = 2 * SCK_HALF;
  localparam int GW    = $clog2(GAP_N + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_N - 1);

  seq_state_e          state_q;
  setup_t              cur_q;
  logic [HDR_MAX-1:0]  out_sr;
  logic [DATA_W-1:0]   in_sr;
  logic [6:0]          bits_left;
  logic [GW-1:0]       gap_cnt;

  setup_t              sel;
  logic [6:0]          data_units;
  logic [3:0]          sample;
  logic [DATA_W-1:0]   swapped;

  assign sel        = setup_q[rd_cs];
  assign data_units = 7'(DATA_W) >> lane_shift(cur_q.mode);
  assign run        = (state_q == S_SEND) || (state_q == S_DUMMY) || (state_q == S_DATA);
  assign io_out     = {3'b000, out_sr[HDR_MAX-1]};

  always_comb begin
    case (lane_count(cur_q.mode))
      3'd4:    sample = io_in;
      3'd2:    sample = {2'b00, io_in[1:0]};
      default: sample = {3'b000, io_in[1]};
    endcase
  end

  // First received byte lands in the lowest lane.
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      swapped[8*b +: 8] = in_sr[DATA_W - 8 - 8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cur_q     <= '0;
      out_sr    <= '0;
      in_sr     <= '0;
      bits_left <= '0;
      gap_cnt   <= '0;
      rd_ready  <= 1'b0;
      rd_data   <= '0;
      rd_err    <= 1'b0;
      cs_n      <= '1;
      io_oe     <= '0;
    end else begin
      rd_ready <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (rd_valid) begin
            if (!mm_en) begin
              rd_ready <= 1'b1;
              rd_err   <= 1'b1;
              rd_data  <= '0;
              gap_cnt  <= '0;
              state_q  <= S_GAP;
            end else begin
              cur_q     <= sel;
              cs_n      <= ~(NCS'(1) << rd_cs);
              out_sr    <= {sel.opcode, rd_addr << {2'd3 - sel.addr_m1, 3'b000}};
              bits_left <= 7'd16 + {2'b00, sel.addr_m1, 3'b000};
              io_oe     <= 4'b0001;
              in_sr     <= '0;
              state_q   <= S_SEND;
            end
          end
        end
        S_SEND: begin
          if (sck_fall) begin
            if (bits_left == 7'd1) begin
              out_sr <= '0;
              io_oe  <= 4'b0000;
              if (cur_q.dummy != 2'd0) begin
                bits_left <= {2'b00, cur_q.dummy, 3'b000};
                state_q   <= S_DUMMY;
              end else begin
                bits_left <= data_units;
                state_q   <= S_DATA;
              end
            end else begin
              out_sr    <= out_sr << 1;
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        S_DUMMY: begin
          if (sck_fall) begin
            if (bits_left == 7'd1) begin
              bits_left <= data_units;
              state_q   <= S_DATA;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        S_DATA: begin
          if (sck_rise) begin
            in_sr <= (in_sr << lane_count(cur_q.mode)) | DATA_W'(sample);
          end
          if (sck_fall) begin
            if (bits_left == 7'd1) begin
              cs_n     <= '1;
              rd_ready <= 1'b1;
              rd_err   <= 1'b0;
              rd_data  <= swapped;
              gap_cnt  <= '0;
              state_q  <= S_GAP;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            state_q <= S_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: at most one chip select active
  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R10: completion is a single-cycle pulse
  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  // R10: a good completion arrives with the flash already deselected
  p_ready_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_err) |-> (&cs_n));

  // R2: a refused read touches no pin
  p_refused_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && rd_valid && !mm_en) |=> ((&cs_n) && io_oe == 4'b0000 && rd_err));

  // R5: dummy and data phases leave every line undriven
  p_turnaround_hiz_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DUMMY || state_q == S_DATA) |-> (io_oe == 4'b0000));

endmodule

// File: rtl/flash_mm_xlate.sv
module flash_mm_xlate
  import flash_mm_pkg::*;
#(
  parameter  int NCS      = 4,
  parameter  int CFG_AW   = 8,
  parameter  int DATA_W   = 32,
  parameter  int SCK_HALF = 2,
  localparam int CS_W     = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              mm_path_en,
  input  logic              rd_valid,
  input  logic [CS_W-1:0]   rd_cs,
  input  logic [31:0]       rd_addr,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output logic              flash_sck,
  output logic [NCS-1:0]    flash_cs_n,
  output logic [3:0]        flash_io_out,
  output logic [3:0]        flash_io_oe,
  input  logic [3:0]        flash_io_in
);

  setup_t [NCS-1:0] setup_q;
  logic             run;
  logic             sck_rise;
  logic             sck_fall;

  flash_mm_cfg #(
    .NCS (NCS),
    .AW  (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sw_en     (mm_path_en),
    .setup_q   (setup_q)
  );

  flash_mm_sck #(
    .SCK_HALF (SCK_HALF)
  ) u_sck (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sck  (flash_sck),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  flash_mm_seq #(
    .NCS      (NCS),
    .CS_W     (CS_W),
    .DATA_W   (DATA_W),
    .SCK_HALF (SCK_HALF)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .mm_en    (mm_path_en),
    .setup_q  (setup_q),
    .rd_valid (rd_valid),
    .rd_cs    (rd_cs),
    .rd_addr  (rd_addr),
    .io_in    (flash_io_in),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .run      (run),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .cs_n     (flash_cs_n),
    .io_out   (flash_io_out),
    .io_oe    (flash_io_oe)
  );

  // R4: serial clock is low while no flash is selected
  p_sck_low_deselected_r4: assert property (@(posedge clk) disable iff (rst)
    (&flash_cs_n) |-> !flash_sck);

  // R11: a deselect lasts more than one system clock
  p_cs_hold_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(&flash_cs_n) |=> (&flash_cs_n));

endmodule

// File: tb/flash_mm_xlate_tb.sv
module flash_mm_xlate_tb;

  localparam int NCS      = 4;
  localparam int SCK_HALF = 2;

  typedef struct packed {
    logic [1:0]  cs;
    logic [7:0]  op;
    logic [1:0]  am1;
    logic [1:0]  nd;
    logic [1:0]  mode;
    logic [31:0] addr;
    logic [31:0] stream;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h03, 2'd2, 2'd0, 2'd0, 32'h0012_3456, 32'hA55A_0FF0},
    '{2'd1, 8'h3B, 2'd2, 2'd1, 2'd1, 32'h00AB_CDEF, 32'h1234_5678},
    '{2'd2, 8'h6B, 2'd3, 2'd1, 2'd3, 32'h89AB_CDEF, 32'hDEAD_BEEF},
    '{2'd3, 8'hEB, 2'd1, 2'd3, 2'd3, 32'h0000_BEEF, 32'h0F1E_2D3C},
    '{2'd0, 8'h0B, 2'd0, 2'd2, 2'd2, 32'h0000_007F, 32'h8000_0001},
    '{2'd1, 8'h3B, 2'd2, 2'd0, 2'd1, 32'h0000_0000, 32'hFFFF_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mm_path_en;
  logic        rd_valid = 1'b0;
  logic [1:0]  rd_cs = '0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic        rd_err;
  logic        flash_sck;
  logic [3:0]  flash_cs_n;
  logic [3:0]  flash_io_out;
  logic [3:0]  flash_io_oe;
  logic [3:0]  flash_io_in;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_mm_xlate #(
    .NCS      (NCS),
    .SCK_HALF (SCK_HALF)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .mm_path_en   (mm_path_en),
    .rd_valid     (rd_valid),
    .rd_cs        (rd_cs),
    .rd_addr      (rd_addr),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .rd_err       (rd_err),
    .flash_sck    (flash_sck),
    .flash_cs_n   (flash_cs_n),
    .flash_io_out (flash_io_out),
    .flash_io_oe  (flash_io_oe),
    .flash_io_in  (flash_io_in)
  );

  // ---------------- flash model ----------------
  logic        cs_idle;
  int          rises = 0;
  int          hdr_len = 16;
  int          pre_len = 16;
  int          lanes = 1;
  logic [31:0] stream = '0;
  logic [39:0] cap = '0;
  int          bad_oe = 0;
  int          cs_falls = 0;
  logic [3:0]  cs_seen = '1;
  int          gapc = 0;
  int          last_gap = 0;

  assign cs_idle = &flash_cs_n;

  always @(negedge cs_idle) begin
    rises    = 0;
    cap      = '0;
    cs_falls = cs_falls + 1;
    cs_seen  = flash_cs_n;
    last_gap = gapc;
  end

  always @(posedge flash_sck) begin
    if (!cs_idle) begin
      if (rises < hdr_len) begin
        cap = {cap[38:0], flash_io_out[0]};
        if (flash_io_oe != 4'b0001) bad_oe = bad_oe + 1;
      end else if (flash_io_oe != 4'b0000) begin
        bad_oe = bad_oe + 1;
      end
      rises = rises + 1;
    end
  end

  always @(posedge clk) gapc <= cs_idle ? gapc + 1 : 0;

  always_comb begin
    int idx;
    logic [31:0] unit;
    flash_io_in = 4'b0000;
    idx = rises - pre_len;
    if (idx >= 0 && idx < 32 / lanes) begin
      unit = (stream >> (32 - (idx + 1) * lanes)) & ((32'd1 << lanes) - 32'd1);
      if (lanes == 1) flash_io_in[1] = unit[0];
      else            flash_io_in    = unit[3:0];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] cs, input logic [31:0] a,
                         output logic [31:0] d, output logic e, output int rs);
    @(negedge clk);
    rd_valid = 1'b1; rd_cs = cs; rd_addr = a;
    do @(negedge clk); while (!rd_ready);
    d = rd_data; e = rd_err; rs = rises;
    rd_valid = 1'b0;
  endtask

  function automatic int lanes_of(input logic [1:0] m);
    return (m == 2'd3) ? 4 : (m == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [31:0] swap_bytes(input logic [31:0] s);
    return {s[7:0], s[15:8], s[23:16], s[31:24]};
  endfunction

  task automatic arm_model(input vec_t v);
    hdr_len = 16 + 8 * int'(v.am1);
    pre_len = hdr_len + 8 * int'(v.nd);
    lanes   = lanes_of(v.mode);
    stream  = v.stream;
    bad_oe  = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] d;
    logic        e;
    int          rs;
    int          falls0;
    logic [39:0] hdr;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check(flash_cs_n == 4'hF, "R12 cs_n", flash_cs_n, 4'hF);
    check(flash_sck == 1'b0, "R12 sck", flash_sck, 0);
    check(flash_io_oe == 4'h0, "R12 oe", flash_io_oe, 0);
    check(rd_ready == 1'b0, "R12 ready", rd_ready, 0);
    check(mm_path_en == 1'b0, "R12 switch", mm_path_en, 0);

    // R2 refused read with switch clear
    falls0 = cs_falls;
    do_read(2'd0, 32'h100, d, e, rs);
    check(e == 1'b1, "R2 err", e, 1);
    check(cs_falls == falls0, "R2 no cs", cs_falls - falls0, 0);
    check(rs == 0, "R2 no sck", rs, 0);

    // R1 enable switch
    cfg_write(8'h64, 32'h0000_0001);
    check(mm_path_en == 1'b1, "R1 enable", mm_path_en, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int   nab;
      v   = VECS[i];
      nab = int'(v.am1) + 1;
      cfg_write(8'(32'h54 + 4 * int'(v.cs)),
                {18'h0, v.mode, v.nd, v.am1, v.op});
      if (i == 0) begin
        // R3 writes at unused offsets change nothing
        cfg_write(8'h50, 32'hFFFF_FFFF);
        cfg_write(8'h68, 32'hFFFF_FFFF);
      end
      arm_model(v);
      do_read(v.cs, v.addr, d, e, rs);
      hdr = {v.op, v.addr << (8 * (4 - nab))};
      check(e == 1'b0, "R10 err low", e, 0);
      check(d == swap_bytes(v.stream), "R9/R6/R7/R8 data", d, swap_bytes(v.stream));
      check(cap[39:0] == (hdr >> (40 - hdr_len)), "R3/R4 header",
            cap, hdr >> (40 - hdr_len));
      check(rs == pre_len + 32 / lanes, "R5/R10 rising edges", rs, pre_len + 32 / lanes);
      check(bad_oe == 0, "R4/R5 output enables", bad_oe, 0);
      check(cs_seen == ~(4'b0001 << v.cs), "R11 selected cs", cs_seen,
            ~(4'b0001 << v.cs));
    end

    // R11 back-to-back reads keep the deselect gap
    arm_model(VECS[5]);
    do_read(VECS[5].cs, VECS[5].addr, d, e, rs);
    arm_model(VECS[5]);
    do_read(VECS[5].cs, VECS[5].addr, d, e, rs);
    check(last_gap >= 2 * SCK_HALF, "R11 gap", last_gap, 2 * SCK_HALF);
    check(d == swap_bytes(VECS[5].stream), "R7 repeat data", d, swap_bytes(VECS[5].stream));

    // R1 / R2 disable again
    cfg_write(8'h64, 32'hFFFF_FFFE);
    check(mm_path_en == 1'b0, "R1 disable", mm_path_en, 0);
    falls0 = cs_falls;
    do_read(2'd2, 32'h0, d, e, rs);
    check(e == 1'b1, "R2 err after disable", e, 1);
    check(cs_falls == falls0, "R2 no cs after disable", cs_falls - falls0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule